// File: doc/BRIEF.md
# Upstream Packet Frame Receiver

This block takes the upstream serial line from an external sensor-interface PHY. It recovers UART characters from it and groups characters that arrive back to back into one packet. A packet ends when the line has stayed idle for a programmable number of bit periods. The block then checks the packet's own CRC and pulls a sensor value of configurable width, together with its check bits, out of the payload. It checks the sensor CRC or parity and presents the result as a one-cycle report. The report carries the target channel and frame slot, error flags, the sensor status bits taken from the packet header, and interrupt pulses.

The line is sampled once per enable pulse, and the enable runs at sixteen times the bit rate. The RX input must already be synchronous to `clk`. Every packet is laid out as follows. The first character is a header: bits [2:0] give the channel, bits [5:3] the frame and bits [7:6] the sensor status. The payload characters follow. The last character is the packet CRC.

Top module: `psi_upstream_rx`

## Requirements
- R1: A character is a low start bit, eight data bits sent LSB first and a stop bit. The start bit is accepted only if the line is still low on the eighth enable pulse after the falling edge. A shorter low pulse yields no character.
- R2: The line may stay high for cfg_idle_i+1 bit periods (1 to 16) after the last stop bit. In that case the packet closes, and rep_valid_o pulses for one cycle, 16*(cfg_idle_i+1) clocks after the final clock of that stop bit (enable on every clock). Shorter gaps keep the characters in one packet.
- R3: The packet CRC is CRC-8 with polynomial 0x07 and initial value 0, run MSB first over every received character including the last. A nonzero remainder sets rep_err_o[2].
- R4: A packet with rep_err_o[2] set is reported as channel 0, frame 1. Any other packet reports header bits [2:0] as the channel and [5:3] as the frame.
- R5: The payload word is made of characters 1 to cfg_chars_i-2, first character in the lowest byte. rep_data_o holds its low cfg_len_i bits followed by the check bits (3 or 1), and all higher bits are zero.
- R6: With cfg_sens_crc_i=1 the 3 bits above the data must equal a CRC-3 of the data. That CRC uses polynomial x^3+x+1 and initial value 111, MSB first. With cfg_sens_crc_i=0 the data bits plus the parity bit must have even parity. A failure sets rep_err_o[3].
- R7: A stop bit sampled low in any character of the packet sets rep_err_o[0].
- R8: rep_err_o[1] is set when the number of characters received differs from cfg_chars_i.
- R9: irq_any_o pulses with every report. irq_ok_o pulses only when rep_err_o AND cfg_irq_mask_i is zero.
- R10: Header bits [7:6] appear unchanged on rep_sens_o, and irq_sens_o pulses with a report whose status is nonzero.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Upstream serial line, synchronous to clk |
| os_tick_i | input | 1 | Sampling enable at 16x bit rate |
| cfg_idle_i | input | 4 | Idle bits closing a packet, minus one |
| cfg_chars_i | input | 3 | Characters per packet, 3 to 6 |
| cfg_len_i | input | 5 | Sensor data length, 8 to 28 |
| cfg_sens_crc_i | input | 1 | 1: 3-bit sensor CRC, 0: parity bit |
| cfg_irq_mask_i | input | 4 | Errors that block irq_ok_o |
| rep_valid_o | output | 1 | Report strobe |
| rep_data_o | output | 32 | Sensor data with its check bits |
| rep_chan_o | output | 3 | Target channel |
| rep_frame_o | output | 3 | Target frame |
| rep_err_o | output | 4 | Errors: [0] stop, [1] length, [2] packet CRC, [3] sensor check |
| rep_sens_o | output | 2 | Sensor status from header |
| irq_ok_o | output | 1 | Report without selected errors |
| irq_any_o | output | 1 | Any report |
| irq_sens_o | output | 1 | Sensor status nonzero |

## Verification
A packet's report is due 159+16*(cfg_idle_i+1) clocks after the edge that first samples its last start bit. The bench notes that edge as it drives the start bit and queues the expected report with this cycle attached. On every falling clock edge the bench compares rep_valid_o with whether a report is due in that cycle, so an early, late or extra report fails at once. The fields and interrupts are compared only in the cycle the strobe is due, and a bad stop bit is held low just past mid-bit so that this timing does not change.

// File: rtl/psi_rx_pkg.sv
// Shared constants, types and the packet CRC step for the upstream receiver.
package psi_rx_pkg;
    localparam int ERR_W    = 4;
    localparam int ERR_STOP = 0;
    localparam int ERR_LEN  = 1;
    localparam int ERR_PCRC = 2;
    localparam int ERR_SCHK = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // One byte of CRC-8, polynomial 0x07, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int k = 0; k < 8; k++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/psi_uart_rx.sv
// Oversampled UART character receiver.
// Assumes rx_i is already synchronous to clk. tick_i marks each of the
// OS_RATE samples per bit. A start bit is confirmed at mid-bit. Data is
// taken LSB first on every following bit centre. The stop bit level is
// reported with the character.
module psi_uart_rx
    import psi_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick_i,
    output logic       char_valid_o,
    output logic [7:0] char_data_o,
    output logic       stop_ok_o,
    output logic       idle_tick_o
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] HALF = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

    rx_state_e     state;
    logic [CW-1:0] tcnt;
    logic [2:0]    bcnt;
    logic [7:0]    shreg;

    // Sample on which the line is idle and no character is in progress.
    assign idle_tick_o = tick_i && (state == RX_IDLE) && rx_i;

    // Character framing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= RX_IDLE;
            tcnt         <= '0;
            bcnt         <= '0;
            shreg        <= '0;
            char_valid_o <= 1'b0;
            char_data_o  <= '0;
            stop_ok_o    <= 1'b0;
        end else begin
            char_valid_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        if (!rx_i) state <= RX_START;
                    end
                    RX_START: begin
                        if (tcnt == HALF) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= rx_i ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt  <= '0;
                            shreg <= {rx_i, shreg[7:1]};
                            if (bcnt == 3'd7) state <= RX_STOP;
                            bcnt <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt         <= '0;
                            char_valid_o <= 1'b1;
                            char_data_o  <= shreg;
                            stop_ok_o    <= rx_i;
                            state        <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R1: a character strobe lasts one cycle.
    a_r1_single_char: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |=> !char_valid_o);
    // R1: data phase is entered only with the line low at the mid-bit sample.
    a_r1_start_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> $past(!rx_i));
endmodule

// File: rtl/psi_pkt_asm.sv
// Packet assembler. It stores the characters of the open packet, keeps a
// running packet CRC and a stop-error flag, and measures the idle gap.
// It raises close_o on the idle sample that completes the configured gap.
// Assumes characters come from psi_uart_rx, whose idle samples start right
// after the stop-bit centre.
module psi_pkt_asm
    import psi_rx_pkg::*;
#(
    parameter int OS_RATE   = 16,
    parameter int MAX_CHARS = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          char_valid_i,
    input  logic [7:0]                    char_data_i,
    input  logic                          stop_ok_i,
    input  logic                          idle_tick_i,
    input  logic [3:0]                    cfg_idle_i,
    output logic                          close_o,
    output logic [MAX_CHARS-1:0][7:0]     bytes_o,
    output logic [2:0]                    cnt_o,
    output logic [7:0]                    crc_o,
    output logic                          stop_err_o
);
    localparam int GAP_W = $clog2(OS_RATE * 17 + 1);

    logic             open_q;
    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_lim;

    // Idle samples from stop centre to the end of the configured gap.
    assign gap_lim = GAP_W'(OS_RATE / 2 - 1)
                   + GAP_W'(OS_RATE) * (GAP_W'(cfg_idle_i) + GAP_W'(1));
    assign close_o = open_q && idle_tick_i && !char_valid_i
                   && (gap_cnt == gap_lim - GAP_W'(1));

    // Packet bookkeeping: count, CRC, stop error and gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            gap_cnt    <= '0;
            cnt_o      <= '0;
            crc_o      <= '0;
            stop_err_o <= 1'b0;
        end else if (char_valid_i) begin
            open_q     <= 1'b1;
            gap_cnt    <= idle_tick_i ? GAP_W'(1) : '0;
            cnt_o      <= (cnt_o == 3'd7) ? cnt_o : cnt_o + 1'b1;
            crc_o      <= crc8_step(crc_o, char_data_i);
            stop_err_o <= stop_err_o | !stop_ok_i;
        end else if (close_o) begin
            open_q     <= 1'b0;
            gap_cnt    <= '0;
            cnt_o      <= '0;
            crc_o      <= '0;
            stop_err_o <= 1'b0;
        end else if (open_q && idle_tick_i) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // One storage slot per character position, cleared when a packet closes.
    for (genvar g = 0; g < MAX_CHARS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || close_o) begin
                bytes_o[g] <= '0;
            end else if (char_valid_i && cnt_o == 3'(g)) begin
                bytes_o[g] <= char_data_i;
            end
        end
    end

    // R2: a new character restarts the gap measurement.
    a_r2_gap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_i |=> (gap_cnt <= GAP_W'(1)));
    // R2: a packet closes only while one is open.
    a_r2_close_open: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> !open_q);
endmodule

// File: rtl/psi_pkt_decode.sv
// Combinational decoder for a closed packet. It extracts the payload word,
// masks the sensor field, checks the sensor CRC-3 or parity, flags length
// and packet CRC errors, and routes a packet with a bad CRC to channel 0,
// frame 1. Assumes the data field plus its check bits fit in the payload.
module psi_pkt_decode
    import psi_rx_pkg::*;
#(
    parameter int MAX_CHARS = 6,
    parameter int DATA_MAX  = 28
) (
    input  logic [MAX_CHARS-1:0][7:0] bytes_i,
    input  logic [2:0]                cnt_i,
    input  logic [7:0]                crc_i,
    input  logic                      stop_err_i,
    input  logic [2:0]                cfg_chars_i,
    input  logic [4:0]                cfg_len_i,
    input  logic                      cfg_sens_crc_i,
    output logic [31:0]               data_o,
    output logic [2:0]                chan_o,
    output logic [2:0]                frame_o,
    output logic [ERR_W-1:0]          err_o,
    output logic [1:0]                sens_o
);
    localparam int PAY_W = 8 * (MAX_CHARS - 2);

    logic [PAY_W-1:0] payload;
    logic [PAY_W-1:0] fmask;
    logic [PAY_W-1:0] pmask;
    logic [5:0]       fwidth;
    logic [2:0]       crc3;
    logic             fb;
    logic             pcrc_bad;
    logic             schk_bad;

    // Gather payload bytes, first character in the lowest byte.
    always_comb begin
        payload = '0;
        for (int i = 1; i <= MAX_CHARS - 2; i++) begin
            if (i <= int'(cfg_chars_i) - 2) payload[8*(i-1) +: 8] = bytes_i[i];
        end
    end

    // Sensor check: CRC-3 over data MSB first, or even parity.
    always_comb begin
        crc3 = 3'b111;
        fb   = 1'b0;
        for (int i = DATA_MAX - 1; i >= 0; i--) begin
            if (i < int'(cfg_len_i)) begin
                fb   = crc3[2] ^ payload[i];
                crc3 = {crc3[1], crc3[0] ^ fb, fb};
            end
        end
        pmask    = (PAY_W'(1) << (cfg_len_i + 5'd1)) - PAY_W'(1);
        schk_bad = cfg_sens_crc_i ? (crc3 != payload[cfg_len_i +: 3])
                                  : ^(payload & pmask);
    end

    // Field mask, error vector and routing.
    always_comb begin
        fwidth   = {1'b0, cfg_len_i} + (cfg_sens_crc_i ? 6'd3 : 6'd1);
        fmask    = (PAY_W'(1) << fwidth) - PAY_W'(1);
        data_o   = 32'(payload & fmask);
        pcrc_bad = (crc_i != 8'h00);
        err_o    = '0;
        err_o[ERR_STOP] = stop_err_i;
        err_o[ERR_LEN]  = (cnt_i != cfg_chars_i);
        err_o[ERR_PCRC] = pcrc_bad;
        err_o[ERR_SCHK] = schk_bad;
        chan_o   = pcrc_bad ? 3'd0 : bytes_i[0][2:0];
        frame_o  = pcrc_bad ? 3'd1 : bytes_i[0][5:3];
        sens_o   = bytes_i[0][7:6];
    end
endmodule

// File: rtl/psi_upstream_rx.sv
// Top of the upstream packet receiver: UART front end, packet assembler
// and decoder. The report and interrupt pulses are registered on the
// cycle the packet closes. Assumes rx_i is synchronous and the
// configuration is stable while a packet is in flight.
module psi_upstream_rx
    import psi_rx_pkg::*;
#(
    parameter int OS_RATE   = 16,
    parameter int MAX_CHARS = 6,
    parameter int DATA_MAX  = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_i,
    input  logic        os_tick_i,
    input  logic [3:0]  cfg_idle_i,
    input  logic [2:0]  cfg_chars_i,
    input  logic [4:0]  cfg_len_i,
    input  logic        cfg_sens_crc_i,
    input  logic [3:0]  cfg_irq_mask_i,
    output logic        rep_valid_o,
    output logic [31:0] rep_data_o,
    output logic [2:0]  rep_chan_o,
    output logic [2:0]  rep_frame_o,
    output logic [3:0]  rep_err_o,
    output logic [1:0]  rep_sens_o,
    output logic        irq_ok_o,
    output logic        irq_any_o,
    output logic        irq_sens_o
);
    logic                      ch_valid, ch_stop_ok, idle_tick, close;
    logic [7:0]                ch_data, pcrc;
    logic [MAX_CHARS-1:0][7:0] pbytes;
    logic [2:0]                pcnt, d_chan, d_frame;
    logic                      pstop_err;
    logic [31:0]               d_data;
    logic [ERR_W-1:0]          d_err;
    logic [1:0]                d_sens;

    psi_uart_rx #(.OS_RATE(OS_RATE)) u_uart (
        .clk, .rst_n, .rx_i, .tick_i(os_tick_i),
        .char_valid_o(ch_valid), .char_data_o(ch_data),
        .stop_ok_o(ch_stop_ok), .idle_tick_o(idle_tick)
    );

    psi_pkt_asm #(.OS_RATE(OS_RATE), .MAX_CHARS(MAX_CHARS)) u_asm (
        .clk, .rst_n, .char_valid_i(ch_valid), .char_data_i(ch_data),
        .stop_ok_i(ch_stop_ok), .idle_tick_i(idle_tick), .cfg_idle_i,
        .close_o(close), .bytes_o(pbytes), .cnt_o(pcnt), .crc_o(pcrc),
        .stop_err_o(pstop_err)
    );

    psi_pkt_decode #(.MAX_CHARS(MAX_CHARS), .DATA_MAX(DATA_MAX)) u_dec (
        .bytes_i(pbytes), .cnt_i(pcnt), .crc_i(pcrc), .stop_err_i(pstop_err),
        .cfg_chars_i, .cfg_len_i, .cfg_sens_crc_i,
        .data_o(d_data), .chan_o(d_chan), .frame_o(d_frame),
        .err_o(d_err), .sens_o(d_sens)
    );

    // Register the report and interrupt pulses on packet close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_valid_o <= 1'b0;
            rep_data_o  <= '0;
            rep_chan_o  <= '0;
            rep_frame_o <= '0;
            rep_err_o   <= '0;
            rep_sens_o  <= '0;
            irq_ok_o    <= 1'b0;
            irq_any_o   <= 1'b0;
            irq_sens_o  <= 1'b0;
        end else begin
            rep_valid_o <= close;
            irq_any_o   <= close;
            irq_ok_o    <= close && ((d_err & cfg_irq_mask_i) == '0);
            irq_sens_o  <= close && (d_sens != 2'b00);
            if (close) begin
                rep_data_o  <= d_data;
                rep_chan_o  <= d_chan;
                rep_frame_o <= d_frame;
                rep_err_o   <= d_err;
                rep_sens_o  <= d_sens;
            end
        end
    end

    // R2: reports are isolated single-cycle pulses.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid_o |=> !rep_valid_o);
    // R4: a packet CRC failure always lands in channel 0, frame 1.
    a_r4_crc_route: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid_o && rep_err_o[ERR_PCRC]) |-> (rep_chan_o == 3'd0 && rep_frame_o == 3'd1));
    // R9: the error-free interrupt never fires without the any-packet one.
    a_r9_ok_needs_any: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ok_o |-> irq_any_o);
    // R10: the status interrupt accompanies a report with nonzero status.
    a_r10_sens_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sens_o |-> (rep_valid_o && rep_sens_o != 2'b00));
endmodule

// File: tb/tb_psi_upstream_rx.sv
// Bench for psi_upstream_rx: drives characters bit by bit and predicts each
// report and its due cycle with a behavioural model. rep_valid_o is compared
// on every clock.
module tb_psi_upstream_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        tick = 1'b1;
    logic [3:0]  cfg_idle = 4'd2;
    logic [2:0]  cfg_chars = 3'd4;
    logic [4:0]  cfg_len = 5'd12;
    logic        cfg_scrc = 1'b1;
    logic [3:0]  cfg_mask = 4'hF;
    logic        rep_valid, irq_ok, irq_any, irq_sens;
    logic [31:0] rep_data;
    logic [2:0]  rep_chan, rep_frame;
    logic [3:0]  rep_err;
    logic [1:0]  rep_sens;

    always #2 clk = ~clk;

    psi_upstream_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .cfg_idle_i(cfg_idle), .cfg_chars_i(cfg_chars), .cfg_len_i(cfg_len),
        .cfg_sens_crc_i(cfg_scrc), .cfg_irq_mask_i(cfg_mask),
        .rep_valid_o(rep_valid), .rep_data_o(rep_data), .rep_chan_o(rep_chan),
        .rep_frame_o(rep_frame), .rep_err_o(rep_err), .rep_sens_o(rep_sens),
        .irq_ok_o(irq_ok), .irq_any_o(irq_any), .irq_sens_o(irq_sens)
    );

    typedef struct {
        int          due;
        logic [31:0] data;
        logic [2:0]  ch;
        logic [2:0]  fr;
        logic [3:0]  err;
        logic [1:0]  sens;
        logic        ok;
        logic        sirq;
    } exp_t;

    exp_t        expq[$];
    int          cyc = 0;
    int          vectors = 0;
    int          miscompares = 0;
    int          last_t0 = 0;
    bit          done = 1'b0;
    logic [7:0]  pkt[0:7];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] ref_crc8(input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            c = c ^ pkt[i];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic int ref_crc3(input longint d, input int len);
        int c = 7;
        for (int i = len - 1; i >= 0; i--) begin
            int fb = ((c >> 2) & 1) ^ int'((d >> i) & 1);
            c = ((c & 2) << 1) | ((((c & 1) ^ fb)) << 1) | fb;
        end
        return c;
    endfunction

    // Build a well-formed packet of n characters in pkt[] for the current config.
    task automatic build(input int ch, input int fr, input int sens, input longint data, input int n);
        longint w;
        int     len = int'(cfg_len);
        w = data & ((64'd1 << len) - 1);
        if (cfg_scrc) w = w | (longint'(ref_crc3(w, len)) << len);
        else          w = w | (longint'($countones(w) & 1) << len);
        pkt[0] = 8'((sens << 6) | (fr << 3) | ch);
        for (int i = 1; i <= n - 2; i++) pkt[i] = 8'(w >> (8 * (i - 1)));
        pkt[n-1] = ref_crc8(n - 1);
    endtask

    // Behavioural model of the report for the nsent characters just sent.
    task automatic predict(input int nsent, input bit bad_stop);
        exp_t   e;
        longint pay = 0;
        int     len = int'(cfg_len);
        int     fw;
        bit     pbad, sbad;
        for (int i = 1; i <= int'(cfg_chars) - 2; i++)
            if (i < nsent) pay = pay | (longint'(pkt[i]) << (8 * (i - 1)));
        fw     = len + (cfg_scrc ? 3 : 1);
        e.data = 32'(pay & ((64'd1 << fw) - 1));
        pbad   = (ref_crc8(nsent) != 8'h00);
        if (cfg_scrc) sbad = (ref_crc3(pay & ((64'd1 << len) - 1), len) != int'((pay >> len) & 7));
        else          sbad = ($countones(pay & ((64'd1 << (len + 1)) - 1)) % 2) == 1;
        e.err  = {sbad, pbad, nsent != int'(cfg_chars), bad_stop};
        e.ch   = pbad ? 3'd0 : pkt[0][2:0];
        e.fr   = pbad ? 3'd1 : pkt[0][5:3];
        e.sens = pkt[0][7:6];
        e.ok   = ((e.err & cfg_mask) == 4'h0);
        e.sirq = (e.sens != 2'b00);
        e.due  = last_t0 + 159 + 16 * (int'(cfg_idle) + 1);
        expq.push_back(e);
    endtask

    // Drive one character; a bad stop is low through its centre sample only.
    task automatic send_char(input logic [7:0] b, input bit bad_stop);
        rx = 1'b0;
        last_t0 = cyc + 1;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (16) @(negedge clk);
        end
        if (bad_stop) begin
            rx = 1'b0;
            repeat (9) @(negedge clk);
            rx = 1'b1;
            repeat (7) @(negedge clk);
        end else begin
            rx = 1'b1;
            repeat (16) @(negedge clk);
        end
    endtask

    task automatic idle_bits(input int n);
        rx = 1'b1;
        repeat (16 * n) @(negedge clk);
    endtask

    task automatic send_pkt(input int nsent, input int bad_idx);
        for (int k = 0; k < nsent; k++) send_char(pkt[k], k == bad_idx);
        predict(nsent, bad_idx >= 0 && bad_idx < nsent);
        idle_bits(int'(cfg_idle) + 3);
    endtask

    // Every-clock comparison of the report strobe, fields on due cycles.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (expq.size() > 0 && expq[0].due < cyc) void'(expq.pop_front());
            if (expq.size() > 0 && expq[0].due == cyc) begin
                chk("R2 rep_valid_o on due cycle", 32'(rep_valid), 32'd1);
                chk("R9 irq_any_o", 32'(irq_any), 32'd1);
                chk("R5 rep_data_o", rep_data, expq[0].data);
                chk("R4 rep_chan_o", 32'(rep_chan), 32'(expq[0].ch));
                chk("R4 rep_frame_o", 32'(rep_frame), 32'(expq[0].fr));
                chk("R3 R6 R7 R8 rep_err_o", 32'(rep_err), 32'(expq[0].err));
                chk("R10 rep_sens_o", 32'(rep_sens), 32'(expq[0].sens));
                chk("R9 irq_ok_o", 32'(irq_ok), 32'(expq[0].ok));
                chk("R10 irq_sens_o", 32'(irq_sens), 32'(expq[0].sirq));
                void'(expq.pop_front());
            end else begin
                chk("R2 no report outside due cycle", 32'(rep_valid), 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: outputs after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset rep_valid_o", 32'(rep_valid), 32'd0);
        chk("R11 reset rep_data_o", rep_data, 32'd0);
        chk("R11 reset rep_err_o/chan/frame", {rep_err, rep_chan, rep_frame, rep_sens}, 32'd0);
        chk("R11 reset irqs", {irq_ok, irq_any, irq_sens}, 32'd0);
        idle_bits(2);

        // R1: short low glitch gives no character and no report
        rx = 1'b0;
        repeat (5) @(negedge clk);
        idle_bits(6);

        // R3 R5 R6: 4 characters, 12-bit data with CRC-3
        build(3, 2, 0, 64'hABC, 4);
        send_pkt(4, -1);

        // R6: parity variant, 15-bit data
        cfg_scrc = 1'b0; cfg_len = 5'd15;
        build(5, 0, 0, 64'h5A5B, 4);
        send_pkt(4, -1);

        // R5 R10 R2: 6 characters, 28-bit data, one idle bit, status bits set
        cfg_scrc = 1'b1; cfg_len = 5'd28; cfg_chars = 3'd6; cfg_idle = 4'd0;
        build(7, 5, 2, 64'hFEDCBA9, 6);
        send_pkt(6, -1);

        // R2: sixteen idle bits, 5 characters, parity
        cfg_scrc = 1'b0; cfg_len = 5'd20; cfg_chars = 3'd5; cfg_idle = 4'd15;
        build(1, 3, 1, 64'h12345, 5);
        send_pkt(5, -1);

        // R3 R4: corrupted payload, routed to channel 0 frame 1
        cfg_idle = 4'd2; cfg_scrc = 1'b1; cfg_len = 5'd12; cfg_chars = 3'd4;
        build(6, 4, 0, 64'h321, 4);
        pkt[1] = pkt[1] ^ 8'h10;
        send_pkt(4, -1);

        // R6: sensor check error with a valid packet CRC
        build(2, 6, 3, 64'h777, 4);
        pkt[1] = pkt[1] ^ 8'h01;
        pkt[3] = ref_crc8(3);
        send_pkt(4, -1);

        // R7: stop bit low in character 1
        build(4, 1, 0, 64'h0F0, 4);
        send_pkt(4, 1);

        // R8 R9: short packet, length error not selected in the mask
        cfg_chars = 3'd5; cfg_len = 5'd8; cfg_mask = 4'b0101;
        build(3, 3, 0, 64'hC3, 4);
        send_pkt(4, -1);

        // R8: one character too many
        cfg_chars = 3'd4; cfg_mask = 4'hF;
        build(1, 1, 0, 64'h5C, 4);
        pkt[4] = 8'h00;
        send_pkt(5, -1);

        // R2: gap shorter than configured keeps characters in one packet
        cfg_idle = 4'd3; cfg_len = 5'd12;
        build(5, 5, 0, 64'h9E1, 4);
        send_char(pkt[0], 1'b0);
        send_char(pkt[1], 1'b0);
        idle_bits(3);
        send_char(pkt[2], 1'b0);
        send_char(pkt[3], 1'b0);
        predict(4, 1'b0);
        idle_bits(int'(cfg_idle) + 3);

        // R1: receiver resynchronises after another glitch
        rx = 1'b0;
        repeat (7) @(negedge clk);
        idle_bits(8);
        build(0, 2, 0, 64'h456, 4);
        send_pkt(4, -1);

        idle_bits(4);
        chk("R2 all reports seen", 32'(expq.size()), 32'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule